// File: doc/BRIEF.md
# Eight-Input Programmable Interrupt Controller

This block collects up to eight interrupt inputs, ranks them by a fixed priority and raises one interrupt line towards a processor. The processor programs it over a byte-wide write port with a single address bit. While the controller is in the middle of its setup sequence, writes are read as setup words. Once that sequence has finished, writes are read as operation commands.

Setup begins with a restart word written to the even address. The odd-address words that follow give the vector base, then an optional cascade word, then an optional mode word. Which of these optional words are expected depends on flags in the restart word. After setup, the processor writes the mask, issues end-of-interrupt commands and chooses which status register an even-address read returns. It signals acknowledge with a single-cycle pulse and receives an 8-bit vector on the following cycle.

The cascade word and the cascade-related flags steer the setup sequence only. They do not change how requests are handled.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset the mask is all ones, the request and in-service registers are zero, `int_out` is low and `vector` is zero. An even-address read returns the request register, and the controller accepts operation commands.
- R2: A write to the even address with bit 4 set restarts the setup sequence from any state. It clears the mask to zero, returns the read selection to the request register and clears auto-EOI. It also latches three flags: bit 0 means a mode word will follow, bit 1 means single operation, and bit 3 means level triggering.
- R3: During setup, odd-address writes are taken in this order. First comes the vector base, taken from bits 7:3. Next comes a cascade word, only when the single flag is 0. Last comes a mode word, only when the mode-word flag is 1; in it, bit 1 enables auto-EOI. When the sequence is over, the controller is operational.
- R4: In the operational state, an odd-address write loads the mask. A set bit i keeps input i from raising `int_out` and from winning an acknowledge. An odd-address read returns the mask.
- R5: In edge mode, request bit i sets when input i was 0 on one clock edge and is 1 on the next. It clears when an acknowledge grants input i, unless a new rise arrives in that same cycle. In level mode, the request register holds the inputs as sampled on the previous clock edge.
- R6: `int_out` is high exactly when some input i has its request bit set, its mask bit clear, and no in-service bit set at any index from 0 to i. Index 0 has the highest priority.
- R7: On an `ack` pulse, the lowest-index input that meets the R6 condition wins. On the next cycle `vector` equals base*8 + i, the winner's in-service bit is set and, in edge mode, its request bit is cleared. If no input qualifies, `vector` becomes base*8 + 7 and neither register changes.
- R8: With auto-EOI enabled, an acknowledge leaves the in-service register unchanged.
- R9: In the operational state, an even-address write with bits 4 and 3 clear and bit 5 set is an end-of-interrupt. If bit 6 is 0, it clears the lowest-index set in-service bit (the value 0x20). If bit 6 is 1, it clears the in-service bit numbered by bits 2:0. Bit 7 has no effect, and with bit 5 clear the write does nothing.
- R10: In the operational state, an even-address write with bit 4 clear and bits 3 and 1 set selects what even-address reads return. Bit 0 = 1 selects the in-service register and bit 0 = 0 selects the request register. With bit 1 clear, the selection is unchanged.
- R11: When an end-of-interrupt and an acknowledge fall in the same cycle, both take effect. The end-of-interrupt is resolved against the in-service register as it stood before that cycle, and the acknowledge adds its winner's bit.
- R12: During setup, an even-address write with bit 4 clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr | input | 1 | Write strobe for one cycle |
| addr | input | 1 | Register address: 0 even, 1 odd |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data: even address gives the selected status register, odd address gives the mask |
| irq_in | input | 8 | Interrupt request inputs |
| int_out | output | 1 | Interrupt request to the processor |
| ack | input | 1 | Single-cycle acknowledge pulse |
| vector | output | 8 | Vector captured on the last acknowledge |

## Verification
The end-of-interrupt write and the acknowledge pulse can land in the same cycle. Both of them rewrite the in-service register.

The bench provokes this case in two ways. A directed sequence first puts a low-priority input in service, then lets a higher-priority input preempt it, and then issues a non-specific EOI together with the acknowledge. Constrained random cycles also hit the overlap, because they often pair an EOI write with an ack.

The in-service value that results, the read-back and `int_out` are compared with a bench model. In that model, the EOI is resolved against the register as it stood before the cycle, and the acknowledge's bit is added afterwards.

// File: rtl/irq_ctrl8.sv
module irq_ctrl8 #(
  parameter int NIRQ = 8,
  parameter int DW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [NIRQ-1:0] irq_in,
  output logic          int_out,
  input  logic          ack,
  output logic [DW-1:0] vector
);
  localparam int IW = $clog2(NIRQ);
  localparam int BW = DW - IW;

  typedef enum logic [1:0] {S_RUN, S_BASE, S_CASC, S_MODE} seq_t;

  seq_t state;
  logic [NIRQ-1:0] irr, isr, mask, irq_q;
  logic [BW-1:0] base;
  logic lvl, single, need4, aeoi, sel_isr;

  logic [NIRQ-1:0] allow, cand, win_oh, isr_low, ack_set, eoi_clr;
  logic [IW-1:0]   win_id;
  logic            blk;

  logic op_ok, cmd_init, cmd_eoi, cmd_rsel;
  assign op_ok    = (state == S_RUN);
  assign cmd_init = wr && !addr && wdata[4];
  assign cmd_eoi  = wr && !addr && !wdata[4] && !wdata[3] && wdata[5] && op_ok;
  assign cmd_rsel = wr && !addr && !wdata[4] && wdata[3] && wdata[1] && op_ok;

  always_comb begin
    blk = 1'b0;
    allow = '0;
    for (int i = 0; i < NIRQ; i++) begin
      blk = blk | isr[i];
      allow[i] = !blk;
    end
    cand = irr & ~mask & allow;
    win_id = '0;
    win_oh = '0;
    for (int i = NIRQ - 1; i >= 0; i--) begin
      if (cand[i]) begin
        win_id = IW'(i);
        win_oh = NIRQ'(1) << i;
      end
    end
  end

  assign isr_low = isr & (~isr + NIRQ'(1));
  assign int_out = |cand;
  assign ack_set = ack ? win_oh : '0;
  assign eoi_clr = !cmd_eoi ? '0 :
                   wdata[6] ? (NIRQ'(1) << wdata[IW-1:0]) : isr_low;
  assign rdata   = addr ? DW'(mask) : (sel_isr ? DW'(isr) : DW'(irr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_RUN;
      irr     <= '0;
      isr     <= '0;
      mask    <= '1;
      irq_q   <= '0;
      base    <= '0;
      lvl     <= 1'b0;
      single  <= 1'b0;
      need4   <= 1'b0;
      aeoi    <= 1'b0;
      sel_isr <= 1'b0;
      vector  <= '0;
    end else begin
      irq_q <= irq_in;
      irr   <= lvl ? irq_in : ((irr & ~ack_set) | (irq_in & ~irq_q));
      isr   <= (isr & ~eoi_clr) | (aeoi ? '0 : ack_set);
      if (ack) vector <= {base, int_out ? win_id : {IW{1'b1}}};
      if (cmd_init) begin
        state   <= S_BASE;
        mask    <= '0;
        lvl     <= wdata[3];
        single  <= wdata[1];
        need4   <= wdata[0];
        aeoi    <= 1'b0;
        sel_isr <= 1'b0;
      end else if (wr && addr) begin
        case (state)
          S_BASE: begin
            base  <= wdata[DW-1:IW];
            state <= !single ? S_CASC : (need4 ? S_MODE : S_RUN);
          end
          S_CASC: state <= need4 ? S_MODE : S_RUN;
          S_MODE: begin
            aeoi  <= wdata[1];
            state <= S_RUN;
          end
          default: mask <= wdata[NIRQ-1:0];
        endcase
      end else if (cmd_rsel) begin
        sel_isr <= wdata[0];
      end
    end
  end
endmodule

module irq_ctrl8_chk #(
  parameter int NIRQ = 8,
  parameter int DW   = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr,
  input logic          addr,
  input logic [DW-1:0] wdata,
  input logic          ack,
  input logic          int_out,
  input logic          op_ok,
  input logic          aeoi,
  input logic [NIRQ-1:0] irr,
  input logic [NIRQ-1:0] isr,
  input logic [NIRQ-1:0] mask
);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask == '1 && isr == '0 && irr == '0));

  p_init_clears_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !addr && wdata[4]) |=> (mask == '0 && !op_ok));

  p_int_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr & ~mask) != '0));

  p_ack_sets_isr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_out && !aeoi && !wr) |=> ($countones(isr) == $countones($past(isr)) + 1));

  p_aeoi_keeps_isr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && aeoi && !wr) |=> (isr == $past(isr)));

  p_eoi_clears_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !addr && wdata[7:3] == 5'b00100 && op_ok && !ack && isr != '0)
    |=> ($countones(isr) + 1 == $countones($past(isr))));
endmodule

bind irq_ctrl8 irq_ctrl8_chk #(.NIRQ(NIRQ), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .wdata(wdata),
  .ack(ack), .int_out(int_out), .op_ok(op_ok), .aeoi(aeoi),
  .irr(irr), .isr(isr), .mask(mask)
);

// File: tb/irq_ctrl8_test.sv
module irq_ctrl8_test;
  logic clk = 1'b0, rst_n = 1'b0, wr = 1'b0, addr = 1'b0, ack = 1'b0;
  logic [7:0] wdata = '0, irq_in = '0;
  logic [7:0] rdata, vector;
  logic int_out;

  int checks = 0, fails = 0;

  irq_ctrl8 uut (.clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_in(irq_in), .int_out(int_out), .ack(ack), .vector(vector));

  always #5ns clk = ~clk;

  // bench model of the programmer-visible state
  logic [7:0] m_irr = 0, m_isr = 0, m_mask = 8'hFF, m_prev = 0, m_vec = 0;
  logic [4:0] m_base = 0;
  logic m_lvl = 0, m_single = 0, m_need4 = 0, m_aeoi = 0, m_sel = 0;
  int m_st = 0; // 0 run, 1 base, 2 cascade, 3 mode

  function automatic logic [7:0] cand_of(input logic [7:0] r, input logic [7:0] s, input logic [7:0] m);
    logic [7:0] al = 0;
    logic b = 0;
    for (int i = 0; i < 8; i++) begin
      b = b | s[i];
      al[i] = !b;
    end
    return r & ~m & al;
  endfunction

  function automatic logic [7:0] lowbit(input logic [7:0] v);
    return v & (~v + 8'd1);
  endfunction

  function automatic logic [2:0] idx_of(input logic [7:0] oh);
    for (int i = 0; i < 8; i++) if (oh[i]) return 3'(i);
    return 3'd7;
  endfunction

  task automatic chk(input logic ok, input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  task automatic observe(input logic ra, input string tag);
    logic [7:0] er;
    addr = ra;
    #1;
    er = ra ? m_mask : (m_sel ? m_isr : m_irr);
    chk(rdata == er, tag, "rdata", rdata, er);
    chk(int_out == (cand_of(m_irr, m_isr, m_mask) != 0), tag, "int_out",
        {7'd0, int_out}, {7'd0, cand_of(m_irr, m_isr, m_mask) != 0});
    chk(vector == m_vec, tag, "vector", vector, m_vec);
  endtask

  task automatic step(input logic w, input logic a, input logic [7:0] d, input logic [7:0] irq,
                      input logic k, input logic ra, input string tag);
    logic [7:0] cd, aset, clr, rise, irr_n, isr_n;
    wr = w; addr = a; wdata = d; irq_in = irq; ack = k;
    cd = cand_of(m_irr, m_isr, m_mask);
    aset = k ? lowbit(cd) : 8'd0;
    if (k) m_vec = {m_base, (cd != 0) ? idx_of(lowbit(cd)) : 3'd7};
    rise = irq & ~m_prev;
    m_prev = irq;
    irr_n = m_lvl ? irq : ((m_irr & ~aset) | rise);
    clr = 0;
    if (w && !a && m_st == 0 && d[4:3] == 2'b00 && d[5])
      clr = d[6] ? (8'd1 << d[2:0]) : lowbit(m_isr);
    isr_n = (m_isr & ~clr) | (m_aeoi ? 8'd0 : aset);
    if (w && !a && d[4]) begin
      m_st = 1; m_mask = 0; m_lvl = d[3]; m_single = d[1]; m_need4 = d[0];
      m_aeoi = 0; m_sel = 0;
    end else if (w && a) begin
      case (m_st)
        1: begin m_base = d[7:3]; m_st = !m_single ? 2 : (m_need4 ? 3 : 0); end
        2: m_st = m_need4 ? 3 : 0;
        3: begin m_aeoi = d[1]; m_st = 0; end
        default: m_mask = d;
      endcase
    end else if (w && !a && !d[4] && d[3] && d[1] && m_st == 0) begin
      m_sel = d[0];
    end
    m_irr = irr_n;
    m_isr = isr_n;
    @(posedge clk);
    @(negedge clk);
    wr = 0; ack = 0;
    observe(ra, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d, irq;
    logic w, a, k;
    int r;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    observe(1'b1, "R1");
    observe(1'b0, "R1");

    // setup: single, mode word follows, edge
    step(1, 0, 8'h13, 0, 0, 1, "R2");
    step(1, 1, 8'h40, 0, 0, 1, "R3");
    step(1, 0, 8'h0B, 0, 0, 0, "R12");
    step(1, 1, 8'h01, 0, 0, 1, "R3");
    step(1, 1, 8'h00, 0, 0, 1, "R4");
    step(0, 0, 0, 8'h28, 0, 0, "R5");
    step(0, 0, 0, 8'h28, 1, 0, "R7");
    step(0, 0, 0, 8'h28, 0, 0, "R6");
    step(1, 0, 8'h0B, 8'h28, 0, 0, "R10");
    step(1, 0, 8'h20, 8'h28, 0, 0, "R9");
    step(0, 0, 0, 8'h28, 1, 0, "R7");
    step(1, 0, 8'hE5, 8'h28, 0, 0, "R9");
    step(1, 0, 8'h00, 0, 0, 0, "R9");
    step(1, 0, 8'h0A, 0, 0, 0, "R10");
    step(1, 1, 8'h08, 0, 0, 1, "R4");
    step(0, 0, 0, 8'h08, 0, 0, "R4");
    step(0, 0, 0, 8'h08, 1, 0, "R7");
    step(1, 1, 8'h00, 8'h08, 0, 0, "R4");
    step(1, 0, 8'h0B, 8'h08, 1, 0, "R7");
    step(0, 0, 0, 8'h0A, 0, 0, "R6");
    step(1, 0, 8'h20, 8'h0A, 1, 0, "R11");
    step(0, 0, 0, 8'h00, 0, 0, "R11");
    step(0, 0, 0, 8'h01, 0, 0, "R5");
    step(0, 0, 0, 8'h01, 1, 0, "R5");

    // cascaded, no mode word
    step(1, 0, 8'h10, 0, 0, 1, "R2");
    step(1, 1, 8'h50, 0, 0, 1, "R3");
    step(1, 1, 8'h04, 0, 0, 1, "R3");
    step(1, 1, 8'hF0, 0, 0, 1, "R3");
    step(0, 0, 0, 8'h10, 1, 0, "R7");

    // auto-EOI
    step(1, 0, 8'h13, 0, 0, 1, "R2");
    step(1, 1, 8'h60, 0, 0, 1, "R3");
    step(1, 1, 8'h03, 0, 0, 1, "R3");
    step(1, 0, 8'h0B, 0, 0, 0, "R10");
    step(0, 0, 0, 8'h04, 0, 0, "R8");
    step(0, 0, 0, 8'h04, 1, 0, "R8");
    step(1, 0, 8'h0A, 8'h04, 0, 0, "R8");

    // level mode
    step(1, 0, 8'h1A, 0, 0, 1, "R2");
    step(1, 1, 8'h40, 0, 0, 1, "R3");
    step(0, 0, 0, 8'h04, 0, 0, "R5");
    step(0, 0, 0, 8'h00, 0, 0, "R5");
    step(0, 0, 0, 8'h06, 1, 0, "R5");

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      r = int'($urandom % 100);
      w = (r < 35);
      a = $urandom % 3 == 0;
      d = 8'($urandom);
      if (w && !a) begin
        case ($urandom % 6)
          0: d = 8'h20;
          1: d = 8'h60 | (d & 8'h87);
          2: d = 8'h0A | (d & 8'h01);
          3: d = ($urandom % 5 == 0) ? (8'h10 | (d & 8'h0B)) : 8'h20;
          default: d = d & 8'hE7 | 8'h20;
        endcase
      end
      irq = 8'($urandom) & 8'($urandom);
      k = ($urandom % 3 == 0);
      step(w, a, d, irq, k, 1'($urandom), "R6 R7 R9 R11");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule